// File: doc/BRIEF.md
# Processor Status Register with Interrupt Gate

This block keeps the 16-bit status word of a processor core: a two-bit trace control field, the privilege bit, a three-bit interrupt mask and five condition code flags. Software writes the word through a byte-enabled port. The execution unit loads new condition codes as instructions retire. The mask then decides whether the prioritized interrupt level presented to the core is taken.

The upper (system) byte is protected. It changes only while the core is in supervisor mode and the write is qualified as privileged. The lower byte, which holds the condition codes, can be written in either mode. Once supervisor mode is left, only a reset brings it back within this block. The accept decision is registered: the strobe and the accepted level appear one cycle after the request is sampled. The trace request follows an instruction-complete pulse by one cycle whenever tracing is enabled.

Top module: `psr_irq_gate`

## Requirements
- R1: While reset is asserted and right after it is released, `sr` reads 16'h2700 (trace field 00, supervisor bit 13 set, mask bits 10:8 = 111, condition codes 0), and `irq_take` and `trace_req` are low.
- R2: A write with `wr_be[0]` set loads `wr_data[4:0]` into `sr[4:0]` at the next edge in either privilege mode, and bits 7:5 always read as zero.
- R3: A write with `wr_be[1]` set, while `sup` is 1 and `priv_ok` is 1, loads bits 15:14, 13 and 10:8 from `wr_data` at the next edge, and bits 12:11 always read as zero.
- R4: An upper-byte write made while `sup` is 0 or `priv_ok` is 0 leaves `sr[15:8]` unchanged.
- R5: `cc_load` copies `cc_in` into `sr[4:0]` in the order extend, negative, zero, overflow, carry from bit 4 down to bit 0. A lower-byte write in the same cycle takes precedence over `cc_load`.
- R6: A request level of 1 to 6 is accepted only when it is strictly greater than the mask. An accepted request raises `irq_take` one cycle later, with `irq_take_level` equal to the level.
- R7: A request of level 7 is accepted for every mask value.
- R8: A request level of 0 never raises `irq_take`. When `irq_take` is low, `irq_take_level` reads 0.
- R9: `trace_req` is high for one cycle after each cycle in which `insn_done` is high, if `sr[15:14]` is nonzero. It stays low otherwise.
- R10: `sup` always equals `sr[13]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| wr_data | input | 16 | Write data |
| priv_ok | input | 1 | Qualifies the write as privileged |
| cc_load | input | 1 | Load condition codes from the execution unit |
| cc_in | input | 5 | New condition codes, extend at bit 4 down to carry at bit 0 |
| insn_done | input | 1 | Instruction-complete pulse |
| irq_level | input | 3 | Pending interrupt level, 0 for none |
| sr | output | 16 | Status word |
| sup | output | 1 | Supervisor flag |
| trace_req | output | 1 | Trace request pulse |
| irq_take | output | 1 | Interrupt accept strobe |
| irq_take_level | output | 3 | Level of the accepted request |

## Verification
On every cycle the assertions check four things. The system byte stays stable outside privileged supervisor writes. Level 7 is always taken and level 0 never is. Any accepted level lies above the mask that was in force when the request was sampled. A trace request appears only after an instruction-complete pulse while tracing is enabled. The bench scenarios are needed for the rest: the reset value, the precedence of a lower-byte write over a condition code load, the zero-reading unused bits, and the full sweep of all 64 mask and level pairs against the accept rule.

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
  parameter int LVL_W = 3,
  parameter int CC_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [15:0]      wr_data,
  input  logic             priv_ok,
  input  logic             cc_load,
  input  logic [CC_W-1:0]  cc_in,
  input  logic             insn_done,
  input  logic [LVL_W-1:0] irq_level,
  output logic [15:0]      sr,
  output logic             sup,
  output logic             trace_req,
  output logic             irq_take,
  output logic [LVL_W-1:0] irq_take_level
);
  localparam logic [LVL_W-1:0] LVL_NMI = '1;

  logic [1:0]       trc;
  logic             s_bit;
  logic [LVL_W-1:0] mask;
  logic [CC_W-1:0]  cc;
  logic             accept;
  logic             sys_wr;

  assign sys_wr = wr_en && wr_be[1] && s_bit && priv_ok;
  assign accept = (irq_level == LVL_NMI) || (irq_level > mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trc            <= 2'b00;
      s_bit          <= 1'b1;
      mask           <= LVL_NMI;
      cc             <= '0;
      irq_take       <= 1'b0;
      irq_take_level <= '0;
      trace_req      <= 1'b0;
    end else begin
      if (sys_wr) begin
        trc   <= wr_data[15:14];
        s_bit <= wr_data[13];
        mask  <= wr_data[8 +: LVL_W];
      end
      if (wr_en && wr_be[0]) cc <= wr_data[CC_W-1:0];
      else if (cc_load)      cc <= cc_in;
      irq_take       <= accept;
      irq_take_level <= accept ? irq_level : '0;
      trace_req      <= insn_done && (trc != 2'b00);
    end
  end

  assign sr  = {trc, s_bit, 2'b00, mask, 3'b000, cc};
  assign sup = s_bit;

  a_r4_sys_byte_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup || !priv_ok || !wr_en || !wr_be[1]) |=> $stable(sr[15:8]));

  a_r7_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == LVL_NMI) |=> (irq_take && irq_take_level == LVL_NMI));

  a_r8_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |=> !irq_take);

  a_r6_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_take_level == LVL_NMI || irq_take_level > $past(sr[10:8])));

  a_r9_trace_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_done || sr[15:14] == 2'b00) |=> !trace_req);

  a_r9_trace_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && sr[15:14] != 2'b00) |=> trace_req);
endmodule

// File: tb/tb_psr_irq_gate.sv
module tb_psr_irq_gate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_be = 0;
  logic [15:0] wr_data = 0;
  logic        priv_ok = 0;
  logic        cc_load = 0;
  logic [4:0]  cc_in = 0;
  logic        insn_done = 0;
  logic [2:0]  irq_level = 0;
  logic [15:0] sr;
  logic        sup, trace_req, irq_take;
  logic [2:0]  irq_take_level;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  psr_irq_gate dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .priv_ok(priv_ok), .cc_load(cc_load), .cc_in(cc_in), .insn_done(insn_done),
    .irq_level(irq_level), .sr(sr), .sup(sup), .trace_req(trace_req),
    .irq_take(irq_take), .irq_take_level(irq_take_level)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(logic [1:0] be, logic [15:0] d, logic p);
    @(negedge clk);
    wr_en = 1; wr_be = be; wr_data = d; priv_ok = p;
    @(negedge clk);
    wr_en = 0; wr_be = 0; priv_ok = 0;
  endtask

  initial begin
    do_reset();
    check("R1 sr", sr, 16'h2700);
    check("R1 take", {15'd0, irq_take}, 16'd0);
    check("R1 trace", {15'd0, trace_req}, 16'd0);
    check("R10 sup", {15'd0, sup}, 16'd1);

    wr(2'b01, 16'h00FF, 0);
    check("R2 low byte", sr, 16'h271F);

    @(negedge clk);
    cc_load = 1; cc_in = 5'b10101;
    @(negedge clk);
    cc_load = 0;
    check("R5 cc load", {11'd0, sr[4:0]}, 16'h0015);

    @(negedge clk);
    cc_load = 1; cc_in = 5'h1F; wr_en = 1; wr_be = 2'b01; wr_data = 16'h000A;
    @(negedge clk);
    cc_load = 0; wr_en = 0; wr_be = 0;
    check("R5 write wins", {11'd0, sr[4:0]}, 16'h000A);

    wr(2'b10, 16'hFF00, 1);
    check("R3 sys write", sr[15:8], 16'h00E7);
    wr(2'b10, 16'h0000, 0);
    check("R4 no priv", sr[15:8], 16'h00E7);
    wr(2'b10, 16'h0500, 1);
    check("R3 drop to user", sr[15:8], 16'h0005);
    check("R10 sup user", {15'd0, sup}, 16'd0);
    wr(2'b10, 16'hE700, 1);
    check("R4 user locked", sr[15:8], 16'h0005);
    wr(2'b01, 16'h0013, 0);
    check("R2 user low", {8'd0, sr[7:0]}, 16'h0013);

    do_reset();
    for (int m = 0; m < 8; m++) begin
      wr(2'b10, {8'h20 | 8'(m), 8'h00}, 1);
      for (int l = 0; l < 8; l++) begin
        bit exp_take;
        exp_take = (l == 7) || (l != 0 && l > m);
        @(negedge clk);
        irq_level = 3'(l);
        @(negedge clk);
        irq_level = 0;
        if (l == 7)      check("R7 nmi", {12'd0, irq_take, irq_take_level}, {12'd0, 1'b1, 3'd7});
        else if (l == 0) check("R8 none", {12'd0, irq_take, irq_take_level}, 16'd0);
        else             check("R6 mask", {12'd0, irq_take, irq_take_level},
                               {12'd0, exp_take, exp_take ? 3'(l) : 3'd0});
      end
    end

    @(negedge clk);
    insn_done = 1;
    @(negedge clk);
    insn_done = 0;
    check("R9 trace off", {15'd0, trace_req}, 16'd0);
    wr(2'b10, 16'h6700, 1);
    @(negedge clk);
    insn_done = 1;
    @(negedge clk);
    insn_done = 0;
    check("R9 trace pulse", {15'd0, trace_req}, 16'd1);
    @(negedge clk);
    check("R9 trace one cycle", {15'd0, trace_req}, 16'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule